// File: doc/BRIEF.md
# Nametable Extension Attribute and Tile Mapper

This block sits on the graphics-side address bus of a tile-based video processor and rewrites fetch results per nametable quadrant. A CPU write port loads four quadrant bank registers and four quadrant control registers. Each control register names the memory that backs its quadrant, picks a 1 KiB region of an on-chip extension RAM, and holds two mode flags. With the attribute flag set, palette attribute reads return bits taken from a per-tile extension byte. With the tile-bank flag set, background pattern fetches are moved into a 4 KiB bank named by that same byte.

The video side gives an address and a 2-bit fetch kind every cycle. The block captures the address of each nametable fetch. The attribute and pattern fetches that follow for the same tile use that captured address to find their extension byte. The extension RAM is outside the block: the block drives its read address and takes its read data back combinationally. The override outputs are combinational from the current fetch and the registered state.

Top module: `nte_mapper`

## Requirements
- R1: After reset, the quadrant bank registers hold 0, 0, 1, 1 for quadrants 0 to 3, and every control register is zero. No override is active and the extension address is 0.
- R2: A cycle with `cpu_we`=1 and `cpu_addr` exactly 16'h4126+q (q=0..3) loads `cpu_wdata` into bank register q at the clock edge. Writes with `cpu_we`=0, or with any other 16-bit address, change nothing.
- R3: A cycle with `cpu_we`=1 and `cpu_addr` exactly 16'h412A+q loads control register q. Data bits 7:6 give the memory source, bits 3:2 give the extension region, bit 0 enables the attribute override and bit 1 enables the tile-bank override. Bits 5:4 are ignored.
- R4: When `vid_addr[13]`=1, `nt_src` and `nt_bank` show the source field and the bank register of quadrant `vid_addr[11:10]`. When `vid_addr[13]`=0, both read 0.
- R5: Fetch kinds are 00 none, 01 nametable, 10 attribute and 11 background pattern. On a nametable fetch, `vid_addr[11:0]` is captured at the clock edge. From the next cycle on, `ext_addr` = {region field of the captured quadrant, captured `vid_addr[9:0]`}.
- R6: An attribute fetch with `vid_addr[9:0]` >= 10'h3C0 and the attribute flag of the captured quadrant set drives `attr_ovr`=1. It also drives `attr_data` = `ext_data[7:6]` × 8'h55, which puts the two bits into all four 2-bit fields.
- R7: An attribute fetch below offset 10'h3C0, any other fetch kind, or a clear attribute flag gives `attr_ovr`=0 and `attr_data`=0.
- R8: A background pattern fetch with the tile-bank flag of the captured quadrant set drives `pat_ovr`=1 and `pat_addr` = {`ext_data[5:0]`, `vid_addr[11:0]`}. In every other case `pat_ovr`=0 and `pat_addr` is `vid_addr[12:0]` zero-extended.
- R9: Fetch kinds other than nametable leave the captured address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| vid_kind | input | 2 | Fetch kind: 00 none, 01 nametable, 10 attribute, 11 background pattern |
| vid_addr | input | 14 | Video address bus |
| ext_data | input | 8 | Read data from the extension RAM |
| ext_addr | output | 12 | Read address into the extension RAM |
| nt_src | output | 2 | Memory source of the addressed quadrant |
| nt_bank | output | 8 | Bank register of the addressed quadrant |
| attr_ovr | output | 1 | Attribute read is overridden |
| attr_data | output | 8 | Replacement attribute byte |
| pat_ovr | output | 1 | Pattern address is remapped |
| pat_addr | output | 18 | Pattern address after remapping |

## Verification
The bench goes after the 10'h3C0 boundary on both sides. A design that compared the offset wrongly would let ordinary tile reads take the replicated attribute, or would miss the last attribute row. It also issues attribute and pattern fetches whose own quadrant differs from the captured one. A design that decoded the mode from the live address, or that let non-nametable fetches overwrite the captured address, would then pick the wrong flag or the wrong extension byte. Near-miss register addresses and writes with the strobe low cover loose address decoding. Control writes with bits 5:4 set catch a design that lets those bits leak into the region or mode fields.

// File: rtl/nte_pkg.sv
package nte_pkg;
  typedef enum logic [1:0] {
    FK_NONE = 2'b00,
    FK_NAME = 2'b01,
    FK_ATTR = 2'b10,
    FK_PATT = 2'b11
  } fetch_kind_e;

  localparam int QUADS   = 4;
  localparam int Q_W     = $clog2(QUADS);
  localparam int SRC_W   = 2;
  localparam int MODE_W  = 2;
  localparam int CTRL_W  = SRC_W + Q_W + MODE_W;

  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic [Q_W-1:0]    region;
    logic [MODE_W-1:0] mode;
  } quad_ctrl_t;
endpackage

// File: rtl/nte_regfile.sv
module nte_regfile
  import nte_pkg::*;
#(
  parameter int          BANK_W    = 8,
  parameter logic [15:0] BANK_BASE = 16'h4126,
  parameter logic [15:0] CTRL_BASE = 16'h412A
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_we,
  input  logic [15:0]                  cpu_addr,
  input  logic [7:0]                   cpu_wdata,
  output logic [QUADS-1:0][BANK_W-1:0] bank_q,
  output quad_ctrl_t [QUADS-1:0]       ctrl_q
);
  for (genvar q = 0; q < QUADS; q++) begin : g_quad
    localparam logic [15:0] BANK_A = BANK_BASE + 16'(q);
    localparam logic [15:0] CTRL_A = CTRL_BASE + 16'(q);
    localparam logic [BANK_W-1:0] BANK_RST = (q < QUADS / 2) ? '0 : BANK_W'(1);

    logic              bank_en, ctrl_en;
    logic [BANK_W-1:0] bank_d;
    quad_ctrl_t        ctrl_d;

    always_comb begin
      bank_en = cpu_we && (cpu_addr == BANK_A);
      ctrl_en = cpu_we && (cpu_addr == CTRL_A);
      bank_d  = BANK_W'(cpu_wdata);
      ctrl_d  = '{src: cpu_wdata[7:6], region: cpu_wdata[3:2], mode: cpu_wdata[1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[q] <= BANK_RST;
      end else if (bank_en) begin
        bank_q[q] <= bank_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[q] <= '0;
      end else if (ctrl_en) begin
        ctrl_q[q] <= ctrl_d;
      end
    end
  end
endmodule

// File: rtl/nte_fetch_latch.sv
module nte_fetch_latch
  import nte_pkg::*;
#(
  parameter int OFF_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         vid_kind,
  input  logic [Q_W+OFF_W-1:0] vid_nt_addr,
  output logic [Q_W+OFF_W-1:0] lat_q
);
  logic                 lat_en;
  logic [Q_W+OFF_W-1:0] lat_d;

  always_comb begin
    lat_en = (fetch_kind_e'(vid_kind) == FK_NAME);
    lat_d  = vid_nt_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (lat_en) begin
      lat_q <= lat_d;
    end
  end
endmodule

// File: rtl/nte_override.sv
module nte_override
  import nte_pkg::*;
#(
  parameter int OFF_W   = 10,
  parameter int TILE_W  = 12,
  parameter int TBANK_W = 6,
  parameter int VA_W    = 14
) (
  input  logic [1:0]              vid_kind,
  input  logic [VA_W-1:0]         vid_addr,
  input  logic [MODE_W-1:0]       mode,
  input  logic [7:0]              ext_data,
  output logic                    attr_ovr,
  output logic [7:0]              attr_data,
  output logic                    pat_ovr,
  output logic [TBANK_W+TILE_W-1:0] pat_addr
);
  localparam int PAT_W = TBANK_W + TILE_W;
  localparam logic [OFF_W-1:0] ATTR_START = OFF_W'(10'h3C0);

  logic is_attr_area;

  always_comb begin
    is_attr_area = (vid_addr[OFF_W-1:0] >= ATTR_START);
    attr_ovr  = (fetch_kind_e'(vid_kind) == FK_ATTR) && is_attr_area && mode[0];
    attr_data = attr_ovr ? {4{ext_data[7:6]}} : 8'h00;
    pat_ovr   = (fetch_kind_e'(vid_kind) == FK_PATT) && mode[1];
    if (pat_ovr) begin
      pat_addr = {ext_data[TBANK_W-1:0], vid_addr[TILE_W-1:0]};
    end else begin
      pat_addr = PAT_W'(vid_addr[VA_W-2:0]);
    end
  end
endmodule

// File: rtl/nte_mapper.sv
module nte_mapper
  import nte_pkg::*;
#(
  parameter int          BANK_W    = 8,
  parameter int          OFF_W     = 10,
  parameter int          TILE_W    = 12,
  parameter int          TBANK_W   = 6,
  parameter int          VA_W      = 14,
  parameter logic [15:0] BANK_BASE = 16'h4126,
  parameter logic [15:0] CTRL_BASE = 16'h412A
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_we,
  input  logic [15:0]               cpu_addr,
  input  logic [7:0]                cpu_wdata,
  input  logic [1:0]                vid_kind,
  input  logic [VA_W-1:0]           vid_addr,
  input  logic [7:0]                ext_data,
  output logic [Q_W+OFF_W-1:0]      ext_addr,
  output logic [SRC_W-1:0]          nt_src,
  output logic [BANK_W-1:0]         nt_bank,
  output logic                      attr_ovr,
  output logic [7:0]                attr_data,
  output logic                      pat_ovr,
  output logic [TBANK_W+TILE_W-1:0] pat_addr
);
  localparam int LAT_W = Q_W + OFF_W;

  logic [QUADS-1:0][BANK_W-1:0] bank_q;
  quad_ctrl_t [QUADS-1:0]       ctrl_q;
  logic [LAT_W-1:0]             lat_q;
  logic [Q_W-1:0]               live_quad, lat_quad;
  quad_ctrl_t                   live_ctrl, lat_ctrl;
  logic                         in_nt_space;

  nte_regfile #(
    .BANK_W(BANK_W), .BANK_BASE(BANK_BASE), .CTRL_BASE(CTRL_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .bank_q(bank_q), .ctrl_q(ctrl_q)
  );

  nte_fetch_latch #(.OFF_W(OFF_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .vid_kind(vid_kind),
    .vid_nt_addr(vid_addr[LAT_W-1:0]), .lat_q(lat_q)
  );

  always_comb begin
    in_nt_space = vid_addr[VA_W-1];
    live_quad   = vid_addr[LAT_W-1:OFF_W];
    lat_quad    = lat_q[LAT_W-1:OFF_W];
    live_ctrl   = ctrl_q[live_quad];
    lat_ctrl    = ctrl_q[lat_quad];
    nt_src      = in_nt_space ? live_ctrl.src : '0;
    nt_bank     = in_nt_space ? bank_q[live_quad] : '0;
    ext_addr    = {lat_ctrl.region, lat_q[OFF_W-1:0]};
  end

  nte_override #(
    .OFF_W(OFF_W), .TILE_W(TILE_W), .TBANK_W(TBANK_W), .VA_W(VA_W)
  ) u_ovr (
    .vid_kind(vid_kind), .vid_addr(vid_addr), .mode(lat_ctrl.mode),
    .ext_data(ext_data), .attr_ovr(attr_ovr), .attr_data(attr_data),
    .pat_ovr(pat_ovr), .pat_addr(pat_addr)
  );
endmodule

// File: rtl/nte_mapper_chk.sv
module nte_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_we,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic [1:0]  vid_kind,
  input logic [13:0] vid_addr,
  input logic [11:0] ext_addr,
  input logic [7:0]  nt_bank,
  input logic        attr_ovr,
  input logic [7:0]  attr_data,
  input logic        pat_ovr,
  input logic [17:0] pat_addr
);
  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_kind == 2'b01) |=> (ext_addr[9:0] == $past(vid_addr[9:0])));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_kind != 2'b01) |=> $stable(ext_addr[9:0]));

  p_attr_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    attr_ovr |-> (vid_kind == 2'b10 && attr_data == {4{attr_data[1:0]}}));

  p_attr_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_addr[9:0] < 10'h3C0) |-> !attr_ovr);

  p_pat_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pat_ovr |-> (vid_kind == 2'b11 && pat_addr[11:0] == vid_addr[11:0]));

  p_bank_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == 16'h4126) |=>
      (vid_addr[13:10] != 4'b1000 || cpu_we || nt_bank == $past(cpu_wdata)));
endmodule

bind nte_mapper nte_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .vid_kind(vid_kind), .vid_addr(vid_addr),
  .ext_addr(ext_addr), .nt_bank(nt_bank), .attr_ovr(attr_ovr),
  .attr_data(attr_data), .pat_ovr(pat_ovr), .pat_addr(pat_addr)
);

// File: tb/nte_mapper_tb.sv
module nte_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [1:0]  vid_kind = '0;
  logic [13:0] vid_addr = '0;
  logic [7:0]  ext_data;
  logic [11:0] ext_addr;
  logic [1:0]  nt_src;
  logic [7:0]  nt_bank;
  logic        attr_ovr;
  logic [7:0]  attr_data;
  logic        pat_ovr;
  logic [17:0] pat_addr;

  int n_chk = 0;
  int n_bad = 0;

  int m_bank[4];
  int m_ctrl[4];
  int m_lat;

  always #4 clk = ~clk;

  function automatic logic [7:0] ram_f(input logic [11:0] a);
    int v;
    v = (int'(a) * 7 + (int'(a) >> 3) + 90);
    return v[7:0];
  endfunction

  assign ext_data = ram_f(ext_addr);

  nte_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .vid_kind(vid_kind), .vid_addr(vid_addr),
    .ext_data(ext_data), .ext_addr(ext_addr), .nt_src(nt_src),
    .nt_bank(nt_bank), .attr_ovr(attr_ovr), .attr_data(attr_data),
    .pat_ovr(pat_ovr), .pat_addr(pat_addr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input string ph, input bit we, input int a, input int d,
                      input int kind, input int va);
    int q, lq, ea, ed, e_ao, e_ad, e_po, e_pa;
    @(negedge clk);
    cpu_we = we; cpu_addr = a[15:0]; cpu_wdata = d[7:0];
    vid_kind = kind[1:0]; vid_addr = va[13:0];
    #2;
    q  = (va >> 10) & 3;
    lq = (m_lat >> 10) & 3;
    ea = (((m_ctrl[lq] >> 2) & 3) << 10) | (m_lat & 'h3FF);
    ed = int'(ram_f(ea[11:0]));
    e_ao = (kind == 2 && (va & 'h3FF) >= 'h3C0 && (m_ctrl[lq] & 1)) ? 1 : 0;
    e_ad = e_ao ? ((ed >> 6) * 'h55) : 0;
    e_po = (kind == 3 && (m_ctrl[lq] & 2)) ? 1 : 0;
    e_pa = e_po ? (((ed & 'h3F) << 12) | (va & 'hFFF)) : (va & 'h1FFF);
    chk({ph, " R4 nt_src"},  int'(nt_src),  (va & 'h2000) ? (m_ctrl[q] >> 6) & 3 : 0);
    chk({ph, " R4 nt_bank"}, int'(nt_bank), (va & 'h2000) ? m_bank[q] : 0);
    chk({ph, " R5 ext_addr"}, int'(ext_addr), ea);
    chk({ph, " R6/R7 attr_ovr"}, int'(attr_ovr), e_ao);
    chk({ph, " R6/R7 attr_data"}, int'(attr_data), e_ad);
    chk({ph, " R8 pat_ovr"}, int'(pat_ovr), e_po);
    chk({ph, " R8 pat_addr"}, int'(pat_addr), e_pa);
    @(posedge clk);
    if (we && a >= 'h4126 && a <= 'h4129) m_bank[a - 'h4126] = d & 'hFF;
    if (we && a >= 'h412A && a <= 'h412D) m_ctrl[a - 'h412A] = d & 'hCF;
    if (kind == 1) m_lat = va & 'hFFF;
  endtask

  task automatic idle(input string ph, input int va);
    step(ph, 1'b0, 0, 0, 0, va);
  endtask

  task automatic wr(input string ph, input int a, input int d);
    step(ph, 1'b1, a, d, 0, 'h2000);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    m_bank = '{0, 0, 1, 1};
    m_ctrl = '{0, 0, 0, 0};
    m_lat  = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values seen through every quadrant
    for (int q = 0; q < 4; q++) idle("R1", 'h2000 | (q << 10) | 'h3C5);
    step("R1", 1'b0, 0, 0, 2, 'h23C0);
    step("R1", 1'b0, 0, 0, 3, 'h0123);

    // R2: bank writes, then writes that must be ignored
    for (int q = 0; q < 4; q++) wr("R2", 'h4126 + q, 'h10 * q + 'h0B);
    step("R2", 1'b0, 'h4126, 'hEE, 0, 'h2000);
    wr("R2", 'h5126, 'hDD);
    wr("R2", 'h4125, 'hCC);
    wr("R2", 'h412E, 'hBB);
    for (int q = 0; q < 4; q++) idle("R2", 'h2000 | (q << 10));
    idle("R4", 'h0400);

    // R3: control writes with bits 5:4 set to check they are dropped
    wr("R3", 'h412A, 'hB5);
    wr("R3", 'h412B, 'h7A);
    wr("R3", 'h412C, 'hFF);
    wr("R3", 'h412D, 'h30);
    for (int q = 0; q < 4; q++) idle("R3", 'h2000 | (q << 10));

    // R5..R9: tile sequences across quadrants
    for (int t = 0; t < 40; t++) begin
      for (int q = 0; q < 4; q++) begin
        int off;
        off = (t * 29 + q * 7) & 'h3BF;
        step("R5", 1'b0, 0, 0, 1, 'h2000 | (q << 10) | off);
        step("R6", 1'b0, 0, 0, 2, 'h2000 | (q << 10) | 'h3C0 | (t & 'h3F));
        step("R7", 1'b0, 0, 0, 2, 'h2000 | (q << 10) | 'h3BF);
        step("R9", 1'b0, 0, 0, 2, 'h2000 | (((q + 1) & 3) << 10) | 'h3FF);
        step("R8", 1'b0, 0, 0, 3, (t * 16 + q) | ((t & 1) << 12));
        step("R8", 1'b0, 0, 0, 3, 'h1FF8 - t);
        idle("R9", 'h1000 | t);
      end
      if (t == 19) begin
        wr("R3", 'h412A, 'h02);
        wr("R3", 'h412B, 'h01);
        wr("R3", 'h412C, 'h08);
        wr("R3", 'h412D, 'h0F);
      end
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule